// File: doc/BRIEF.md
# Comparator Edge Flag Unit

This unit sits behind two comparator channels whose outputs have already been filtered and synchronised to the peripheral clock. For each channel it registers the incoming level and compares it with the value from the previous cycle. A 2-bit polarity code selects which transitions count as events. An event sets a sticky interrupt flag for that channel. If wake-up is enabled for the channel, the same event also sets a sticky wake flag.

Software reads a 16-bit status word that holds both kinds of flag plus the registered comparator levels. It clears flags by writing ones to their positions with a single write strobe. A combined interrupt request is raised while any channel with its interrupt enable set holds a flag.

A disabled channel reports its levels as zero and produces no events. The channel keeps tracking its input while disabled, so turning it back on never creates a false edge.

Top module: `cmp_evt_flags`

## Requirements
- R1: After a synchronous reset the status word reads 0 and the interrupt request is low.
- R2: Polarity code 2'b00 sets the channel's interrupt flag (status bit 0 for channel 0, bit 1 for channel 1) on both rising and falling transitions of its level.
- R3: Polarity code 2'b01 sets the interrupt flag on rising transitions only.
- R4: Polarity code 2'b10 sets the interrupt flag on falling transitions only.
- R5: Polarity code 2'b11 sets no flag on any transition.
- R6: The interrupt request is high exactly while some channel has its interrupt enable at 1 and either its interrupt flag or its wake flag set.
- R7: Writing 1 to a flag position with the status write strobe clears that flag. Writing 0 leaves it unchanged, and clearing one flag leaves the others unchanged.
- R8: If a flag is set by an event in the same cycle as a write-1 clear, the flag ends up set.
- R9: A qualifying event sets the channel's wake flag (status bit 8 for channel 0, bit 9 for channel 1) only while that channel's wake enable is 1.
- R10: While a channel is disabled, its level bits read 0 and no transition sets its flags. Enabling a channel whose level has been steady produces no flag.
- R11: While enabled, status bits 4+n and 12+n both show channel n's level as registered at the last clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous reset, active high |
| ch_lvl | input | NCH | Conditioned comparator level per channel |
| ch_en | input | NCH | Channel enable |
| ch_ie | input | NCH | Interrupt enable per channel |
| ch_wke | input | NCH | Wake enable per channel |
| ch_pol | input | 2*NCH | Edge polarity code, two bits per channel |
| st_wr | input | 1 | Status write strobe |
| st_wdata | input | 16 | Status write data, 1 clears a flag |
| st_rdata | output | 16 | Status word |
| irq | output | 1 | Combined interrupt request |

## Verification
A level change applied before a clock edge is seen at that edge. Both flags and the registered level bits show the new value right after that single edge. The interrupt request follows the flags with no further delay, and clear writes take effect at the edge that samples the strobe.

The bench drives every input on a falling edge and reads the status word on the next falling edge, one register stage later. Before each transition it holds a clear write for two cycles, so that any edge caused by its own setup is flushed out.

// File: rtl/cmp_evt_pkg.sv
package cmp_evt_pkg;

    localparam int ST_W    = 16;
    localparam int IF_LSB  = 0;
    localparam int OUT_LSB = 4;
    localparam int WK_LSB  = 8;
    localparam int STS_LSB = 12;
    localparam int MAX_CH  = 4;

    typedef enum logic [1:0] {
        POL_ANY  = 2'b00,
        POL_RISE = 2'b01,
        POL_FALL = 2'b10,
        POL_NONE = 2'b11
    } pol_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    function automatic edge_t edge_of(input logic prev, input logic cur);
        edge_t e;
        e.rise = cur & ~prev;
        e.fall = ~cur & prev;
        return e;
    endfunction

    function automatic logic edge_match(input pol_e pol, input edge_t e);
        case (pol)
            POL_ANY:  return e.rise | e.fall;
            POL_RISE: return e.rise;
            POL_FALL: return e.fall;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/cmp_edge_det.sv
module cmp_edge_det
    import cmp_evt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       lvl,
    input  logic [1:0] pol,
    output logic       hit,
    output logic       lvl_q
);

    edge_t ev;

    // The previous level is tracked even while disabled, so re-enable is quiet.
    always_ff @(posedge clk) begin
        if (rst) lvl_q <= 1'b0;
        else     lvl_q <= lvl;
    end

    always_comb begin
        ev  = edge_of(lvl_q, lvl);
        hit = en & edge_match(pol_e'(pol), ev);
    end

    AST_NO_EDGE_DISABLED: assert property (@(posedge clk) disable iff (rst)
        !en |-> !hit) else $error("event while disabled"); // R10

    AST_RESERVED_QUIET: assert property (@(posedge clk) disable iff (rst)
        (pol == 2'b11) |-> !hit) else $error("reserved code fired"); // R5

    AST_HIT_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (rst)
        hit |-> (lvl != lvl_q)) else $error("event without change"); // R2

    AST_RISE_ONLY: assert property (@(posedge clk) disable iff (rst)
        (hit && pol == 2'b01) |-> lvl) else $error("rise code on fall"); // R3

    AST_FALL_ONLY: assert property (@(posedge clk) disable iff (rst)
        (hit && pol == 2'b10) |-> !lvl) else $error("fall code on rise"); // R4

endmodule

// File: rtl/cmp_flag_cell.sv
module cmp_flag_cell (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic q
);

    // Hardware set takes priority over a software clear in the same cycle.
    always_ff @(posedge clk) begin
        if (rst)      q <= 1'b0;
        else if (set) q <= 1'b1;
        else if (clr) q <= 1'b0;
    end

    AST_SET_STICKS: assert property (@(posedge clk) disable iff (rst)
        set |=> q) else $error("set lost"); // R8

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
        (clr && !set) |=> !q) else $error("clear ignored"); // R7

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!set && !clr) |=> $stable(q)) else $error("flag drifted"); // R7

endmodule

// File: rtl/cmp_evt_flags.sv
module cmp_evt_flags
    import cmp_evt_pkg::*;
#(
    parameter int NCH = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NCH-1:0]     ch_lvl,
    input  logic [NCH-1:0]     ch_en,
    input  logic [NCH-1:0]     ch_ie,
    input  logic [NCH-1:0]     ch_wke,
    input  logic [2*NCH-1:0]   ch_pol,
    input  logic               st_wr,
    input  logic [ST_W-1:0]    st_wdata,
    output logic [ST_W-1:0]    st_rdata,
    output logic               irq
);

    localparam int CH_USED = (NCH < MAX_CH) ? NCH : MAX_CH;

    logic [NCH-1:0] hit;
    logic [NCH-1:0] lvl_q;
    logic [NCH-1:0] if_q;
    logic [NCH-1:0] wk_q;

    for (genvar c = 0; c < CH_USED; c++) begin : g_ch
        cmp_edge_det u_det (
            .clk   (clk),
            .rst   (rst),
            .en    (ch_en[c]),
            .lvl   (ch_lvl[c]),
            .pol   (ch_pol[2*c +: 2]),
            .hit   (hit[c]),
            .lvl_q (lvl_q[c])
        );

        cmp_flag_cell u_if (
            .clk (clk),
            .rst (rst),
            .set (hit[c]),
            .clr (st_wr & st_wdata[IF_LSB + c]),
            .q   (if_q[c])
        );

        cmp_flag_cell u_wk (
            .clk (clk),
            .rst (rst),
            .set (hit[c] & ch_wke[c]),
            .clr (st_wr & st_wdata[WK_LSB + c]),
            .q   (wk_q[c])
        );

        AST_WAKE_GATED: assert property (@(posedge clk) disable iff (rst)
            $rose(wk_q[c]) |-> $past(ch_wke[c])) else $error("wake without enable"); // R9

        AST_WAKE_WITH_IF: assert property (@(posedge clk) disable iff (rst)
            $rose(wk_q[c]) |-> if_q[c]) else $error("wake flag alone"); // R9
    end

    for (genvar c = CH_USED; c < NCH; c++) begin : g_unused
        assign hit[c]   = 1'b0;
        assign lvl_q[c] = 1'b0;
        assign if_q[c]  = 1'b0;
        assign wk_q[c]  = 1'b0;
    end

    always_comb begin
        st_rdata = '0;
        for (int c = 0; c < CH_USED; c++) begin
            st_rdata[IF_LSB + c]  = if_q[c];
            st_rdata[OUT_LSB + c] = lvl_q[c] & ch_en[c];
            st_rdata[WK_LSB + c]  = wk_q[c];
            st_rdata[STS_LSB + c] = lvl_q[c] & ch_en[c];
        end
    end

    assign irq = |(ch_ie & (if_q | wk_q));

    AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (rst)
        (ch_ie == '0) |-> !irq) else $error("irq with no enable"); // R6

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
        irq |-> ((if_q | wk_q) != '0)) else $error("irq with no flag"); // R6

endmodule

// File: tb/tb_cmp_evt_flags.sv
module tb_cmp_evt_flags;

    localparam int NCH = 2;

    logic             clk = 1'b0;
    logic             rst;
    logic [NCH-1:0]   ch_lvl, ch_en, ch_ie, ch_wke;
    logic [2*NCH-1:0] ch_pol;
    logic             st_wr;
    logic [15:0]      st_wdata;
    logic [15:0]      st_rdata;
    logic             irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    cmp_evt_flags #(.NCH(NCH)) dut (
        .clk(clk), .rst(rst), .ch_lvl(ch_lvl), .ch_en(ch_en), .ch_ie(ch_ie),
        .ch_wke(ch_wke), .ch_pol(ch_pol), .st_wr(st_wr), .st_wdata(st_wdata),
        .st_rdata(st_rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_all();
        st_wr = 1'b1; st_wdata = 16'hffff;
        @(negedge clk);
        @(negedge clk);
        st_wr = 1'b0; st_wdata = 16'h0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hang expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; ch_lvl = '0; ch_en = '0; ch_ie = '0; ch_wke = '0; ch_pol = '0;
        st_wr = 1'b0; st_wdata = '0;
        repeat (3) @(negedge clk);
        chk("R1 status", st_rdata, 16'h0);
        chk("R1 irq", irq, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 status after release", st_rdata, 16'h0);

        // Sweep: channel x polarity x direction x wake enable x irq enable
        for (int c = 0; c < NCH; c++) begin
            for (int p = 0; p < 4; p++) begin
                for (int d = 0; d < 2; d++) begin
                    for (int we = 0; we < 2; we++) begin
                        for (int ie = 0; ie < 2; ie++) begin
                            bit    rise;
                            bit    hit;
                            string req;
                            rise = (d == 0);
                            hit  = (p == 0) || (p == 1 && rise) || (p == 2 && !rise);
                            req  = (p == 0) ? "R2" : (p == 1) ? "R3" : (p == 2) ? "R4" : "R5";
                            ch_en  = '1;
                            ch_pol = '0;
                            ch_pol[2*c +: 2] = p[1:0];
                            ch_wke = '0; ch_wke[c] = we[0];
                            ch_ie  = '0; ch_ie[c]  = ie[0];
                            ch_lvl = '0; ch_lvl[c] = ~rise;
                            clear_all();
                            chk("R7 flags cleared", st_rdata & 16'h0303, 16'h0);
                            ch_lvl[c] = rise;
                            @(negedge clk);
                            chk(req, st_rdata[c], hit);
                            chk("R9 wake flag", st_rdata[8 + c], hit & we[0]);
                            chk("R11 level bit", st_rdata[4 + c], rise);
                            chk("R11 mirror bit", st_rdata[12 + c], rise);
                            chk("R6 irq", irq, hit & ie[0]);
                            chk("R2 other channel quiet", st_rdata[1 - c], 1'b0);
                        end
                    end
                end
            end
        end

        // Write-0 and selective clear
        ch_en = '1; ch_pol = '0; ch_wke = 2'b01; ch_ie = 2'b01; ch_lvl = '0;
        clear_all();
        ch_lvl[0] = 1'b1;
        @(negedge clk);
        chk("R7 setup flag", st_rdata[0], 1'b1);
        st_wr = 1'b1; st_wdata = 16'h0000;
        @(negedge clk);
        st_wr = 1'b0;
        @(negedge clk);
        chk("R7 write zero keeps if", st_rdata[0], 1'b1);
        chk("R7 write zero keeps wake", st_rdata[8], 1'b1);
        st_wr = 1'b1; st_wdata = 16'h0100;
        @(negedge clk);
        st_wr = 1'b0; st_wdata = 16'h0;
        chk("R7 wake cleared", st_rdata[8], 1'b0);
        chk("R7 if kept", st_rdata[0], 1'b1);
        chk("R6 irq from if only", irq, 1'b1);
        ch_ie = 2'b00;
        @(negedge clk);
        chk("R6 irq masked", irq, 1'b0);
        ch_ie = 2'b01;
        st_wr = 1'b1; st_wdata = 16'h0001;
        @(negedge clk);
        st_wr = 1'b0; st_wdata = 16'h0;
        chk("R7 if cleared", st_rdata[0], 1'b0);
        chk("R6 irq drops", irq, 1'b0);

        // Set beats clear in the same cycle
        ch_lvl[0] = 1'b0;
        st_wr = 1'b1; st_wdata = 16'h0101;
        @(negedge clk);
        st_wr = 1'b0; st_wdata = 16'h0;
        chk("R8 if set wins", st_rdata[0], 1'b1);
        chk("R8 wake set wins", st_rdata[8], 1'b1);
        clear_all();
        chk("R8 later clear works", st_rdata & 16'h0303, 16'h0);

        // Disabled channel
        ch_en[0] = 1'b0; ch_lvl[0] = 1'b1;
        @(negedge clk);
        chk("R10 level bit zero", st_rdata[4], 1'b0);
        chk("R10 mirror bit zero", st_rdata[12], 1'b0);
        ch_lvl[0] = 1'b0;
        @(negedge clk);
        ch_lvl[0] = 1'b1;
        @(negedge clk);
        chk("R10 no flag while off", st_rdata & 16'h0101, 16'h0);
        ch_en[0] = 1'b1;
        @(negedge clk);
        chk("R10 no flag on enable", st_rdata & 16'h0101, 16'h0);
        chk("R10 level visible", st_rdata[4], 1'b1);
        @(negedge clk);
        chk("R10 still quiet", st_rdata[0], 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule